// File: doc/BRIEF.md
# Clock synthesizer reconfiguration sequencer

This controller sits between a board-level clock-select pin and a frequency synthesizer. The synthesizer has a generic reconfiguration engine. Two divider sets are fixed at build time, one for each possible input reference clock. The controller ignores the pin until the device reports that configuration has finished. After that, it filters the pin and decides whether the synthesizer's counters must change.

When the accepted set differs from the set currently applied, the controller performs a reconfiguration. It writes the multiply and output-divide values into the engine, pulses the engine's start input once, and waits for the busy flag to fall. Every decision ends with a timed synthesizer reset, including decisions that need no reconfiguration. After the reset, the controller waits for lock and then raises `ready`. If the engine stalls, a watchdog sets an error flag and the controller returns to idle. A pin change accepted during a sequence is remembered and handled once the controller is back in idle.

Top module: `clk_reconfig_seq`

## Requirements
- R1: While `cfg_done` is low after reset, `sel_pin` is ignored. No engine write, no start pulse and no synthesizer reset occur.
- R2: `sel_pin` passes through two synchronizing flops. A new level is accepted only after it has been sampled on STABLE_CYC (default 16) consecutive cycles. A pulse that returns earlier causes no activity.
- R3: Accepted select value 0 chooses set 0 and value 1 chooses set 1. `active_set` resets to 0 and takes the target set only when a reconfiguration completes. A reconfiguration happens only when the target differs from `active_set`.
- R4: A reconfiguration writes two values on consecutive cycles, each with `eng_wr` high for one cycle. The multiply value goes first with `eng_type`=2'b01, then the output divider with `eng_type`=2'b10. Both writes come before the start pulse. Outside writes, `eng_type` and `eng_data` are 0.
- R5: `eng_start` is high for exactly one cycle, in the cycle right after the second write.
- R6: Completion is `eng_busy` sampled low after it was sampled high during the wait. While that has not happened, no synthesizer reset is issued.
- R7: `syn_reset` is high for exactly RST_CYC (default 8) cycles after every decision. It starts in the cycle after completion, or in the cycle after the decision when no reconfiguration is needed.
- R8: `ready` drops when a decision is taken. It rises in the cycle after `syn_locked` is sampled high following reset release.
- R9: If WDOG_CYC (default 4096) cycles pass in the busy wait without completion, `err` is set, the controller returns to idle, and `active_set` is unchanged. `err` clears when a later sequence reaches lock.
- R10: A select change accepted while a sequence runs is held as pending. It forces a new decision, including a synthesizer reset, once the controller is idle again, even if the pin has returned to the applied set.
- R11: Synchronous active-high `rst` returns the controller to the configuration wait. All outputs go low and `active_set` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Device configuration has finished |
| sel_pin | input | 1 | Asynchronous reference-clock select pin |
| eng_wr | output | 1 | Engine parameter write strobe |
| eng_type | output | 2 | Counter-type code of the write |
| eng_data | output | DW | Counter value of the write |
| eng_start | output | 1 | Engine start pulse |
| eng_busy | input | 1 | Engine busy flag |
| syn_reset | output | 1 | Synthesizer reset |
| syn_locked | input | 1 | Synthesizer lock indication |
| ready | output | 1 | Clocks settled after the last decision |
| err | output | 1 | Engine watchdog expired |
| active_set | output | 1 | Divider set currently applied |

## Verification
Assertions check the following on every cycle:
- the single-cycle start pulse, and the write order that must come before it;
- the busy-fall condition for leaving the wait;
- lock sampled before `ready` rises;
- `active_set` frozen when `err` rises;
- the pin filter's acceptance rule;
- the timer bounds.

Only the bench scenarios can show the remaining behaviours:
- that a short glitch causes no activity;
- that a no-change decision still pulses the reset for its full width;
- that a there-and-back pin change during a long busy period forces an extra reset sequence;
- that a stalled engine leads to retries that finally succeed.

// File: rtl/clkrc_pkg.sv
`timescale 1ns/1ps
package clkrc_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_CFG  = 3'd0,
    ST_IDLE      = 3'd1,
    ST_WRITE     = 3'd2,
    ST_START     = 3'd3,
    ST_WAIT_BUSY = 3'd4,
    ST_RST_HOLD  = 3'd5,
    ST_WAIT_LOCK = 3'd6
  } seq_state_t;

  // counter-type codes presented with each engine write
  localparam logic [1:0] CT_MULT = 2'b01;
  localparam logic [1:0] CT_ODIV = 2'b10;

  // type code of write slot 0 (multiply) or 1 (output divider)
  function automatic logic [1:0] slot_type(input logic slot);
    return slot ? CT_ODIV : CT_MULT;
  endfunction

endpackage

// File: rtl/clkrc_sel_filter.sv
`timescale 1ns/1ps
module clkrc_sel_filter #(
  parameter int STABLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pin,
  output logic acc,
  output logic valid,
  output logic acc_chg
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic          s1_q, s2_q, cand_q;
  logic [CW-1:0] run_q;
  logic          hit;

  // candidate has been seen for the full window
  assign hit     = (s2_q == cand_q) && (run_q == CW'(STABLE_CYC - 1));
  assign acc_chg = en && valid && hit && (cand_q != acc);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      cand_q <= 1'b0;
      run_q  <= '0;
      acc    <= 1'b0;
      valid  <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      if (s2_q != cand_q) begin
        cand_q <= s2_q;
        run_q  <= '0;
      end else if (!hit) begin
        run_q <= run_q + CW'(1);
      end else begin
        acc   <= cand_q;
        valid <= 1'b1;
      end
    end
  end

  // R2: the accepted level only moves after a full stable window
  assert_accept_after_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && (acc != $past(acc))) |-> (($past(run_q) == CW'(STABLE_CYC - 1)) && ($past(s2_q) == acc)));

endmodule

// File: rtl/clkrc_timer.sv
`timescale 1ns/1ps
module clkrc_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;

  assign expire = run && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (run && !expire) cnt_q <= cnt_q + TW'(1);
  end

  // R7 and R9 windows never count past their limit
  assert_cnt_in_range_R7_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TW'(LIMIT - 1));

endmodule

// File: rtl/clk_reconfig_seq.sv
`timescale 1ns/1ps
module clk_reconfig_seq
  import clkrc_pkg::*;
#(
  parameter int DW         = 9,
  parameter int STABLE_CYC = 16,
  parameter int RST_CYC    = 8,
  parameter int WDOG_CYC   = 4096,
  parameter logic [DW-1:0] SET0_MULT = 9'd40,
  parameter logic [DW-1:0] SET0_ODIV = 9'd4,
  parameter logic [DW-1:0] SET1_MULT = 9'd25,
  parameter logic [DW-1:0] SET1_ODIV = 9'd5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_done,
  input  logic          sel_pin,
  output logic          eng_wr,
  output logic [1:0]    eng_type,
  output logic [DW-1:0] eng_data,
  output logic          eng_start,
  input  logic          eng_busy,
  output logic          syn_reset,
  input  logic          syn_locked,
  output logic          ready,
  output logic          err,
  output logic          active_set
);

  function automatic logic [DW-1:0] pick_param(input logic set_sel, input logic slot);
    case ({set_sel, slot})
      2'b00:   return SET0_MULT;
      2'b01:   return SET0_ODIV;
      2'b10:   return SET1_MULT;
      default: return SET1_ODIV;
    endcase
  endfunction

  seq_state_t state;
  logic widx, tgt, applied, seen_busy, pending, need_dec, ready_q, err_q;

  // named internal events
  logic filt_en, sel_acc, sel_valid, acc_chg;
  logic decide, reconf_needed, busy_done, hold_exp, wd_exp;

  assign filt_en = cfg_done || (state != ST_WAIT_CFG);

  clkrc_sel_filter #(.STABLE_CYC(STABLE_CYC)) u_filter (
    .clk(clk), .rst(rst), .en(filt_en), .pin(sel_pin),
    .acc(sel_acc), .valid(sel_valid), .acc_chg(acc_chg)
  );

  clkrc_timer #(.LIMIT(RST_CYC)) u_hold (
    .clk(clk), .rst(rst), .clr(state != ST_RST_HOLD),
    .run(state == ST_RST_HOLD), .expire(hold_exp)
  );

  clkrc_timer #(.LIMIT(WDOG_CYC)) u_wdog (
    .clk(clk), .rst(rst), .clr(state != ST_WAIT_BUSY),
    .run(state == ST_WAIT_BUSY), .expire(wd_exp)
  );

  assign reconf_needed = (sel_acc != applied);
  assign decide        = need_dec || pending || reconf_needed;
  assign busy_done     = seen_busy && !eng_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT_CFG;
      widx      <= 1'b0;
      tgt       <= 1'b0;
      applied   <= 1'b0;
      seen_busy <= 1'b0;
      pending   <= 1'b0;
      need_dec  <= 1'b1;
      ready_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (acc_chg && (state != ST_IDLE)) pending <= 1'b1;
      case (state)
        ST_WAIT_CFG: if (cfg_done && sel_valid) state <= ST_IDLE;
        ST_IDLE: begin
          if (decide) begin
            tgt      <= sel_acc;
            pending  <= 1'b0;
            need_dec <= 1'b0;
            ready_q  <= 1'b0;
            widx     <= 1'b0;
            state    <= reconf_needed ? ST_WRITE : ST_RST_HOLD;
          end
        end
        ST_WRITE: begin
          if (!widx) widx <= 1'b1;
          else state <= ST_START;
        end
        ST_START: begin
          seen_busy <= 1'b0;
          state     <= ST_WAIT_BUSY;
        end
        ST_WAIT_BUSY: begin
          if (eng_busy) seen_busy <= 1'b1;
          if (busy_done) begin
            applied <= tgt;
            state   <= ST_RST_HOLD;
          end else if (wd_exp) begin
            err_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_RST_HOLD: if (hold_exp) state <= ST_WAIT_LOCK;
        ST_WAIT_LOCK: begin
          if (syn_locked) begin
            ready_q <= 1'b1;
            err_q   <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_WAIT_CFG;
      endcase
    end
  end

  assign eng_wr     = (state == ST_WRITE);
  assign eng_type   = eng_wr ? slot_type(widx) : 2'b00;
  assign eng_data   = eng_wr ? pick_param(tgt, widx) : '0;
  assign eng_start  = (state == ST_START);
  assign syn_reset  = (state == ST_RST_HOLD);
  assign ready      = ready_q;
  assign err        = err_q;
  assign active_set = applied;

  // R1: no progress out of the configuration wait without cfg_done
  assert_hold_before_cfg_R1: assert property (@(posedge clk) disable iff (rst)
    (($past(state) == ST_WAIT_CFG) && !$past(cfg_done)) |-> (state == ST_WAIT_CFG));

  // R4: divider write is preceded by the multiply write
  assert_mult_before_odiv_R4: assert property (@(posedge clk) disable iff (rst)
    (eng_wr && (eng_type == CT_ODIV)) |-> ($past(eng_wr) && ($past(eng_type) == CT_MULT)));

  // R4: start follows the divider write
  assert_start_after_odiv_R4: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> ($past(eng_wr) && ($past(eng_type) == CT_ODIV)));

  // R5: start is a single-cycle pulse
  assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  // R6: leaving the busy wait for reset needs a seen busy that has fallen
  assert_done_needs_fall_R6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RST_HOLD) && ($past(state) == ST_WAIT_BUSY)) |-> (!$past(eng_busy) && $past(seen_busy)));

  // R8: ready only rises after lock was sampled
  assert_ready_after_lock_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(syn_locked) && !syn_reset));

  // R9: a watchdog error returns to idle and keeps the applied set
  assert_err_keeps_set_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> ((state == ST_IDLE) && $stable(active_set)));

endmodule

// File: tb/test_clk_reconfig_seq.sv
`timescale 1ns/1ps
module test_clk_reconfig_seq;

  localparam int STABLE = 16;
  localparam int RSTC   = 8;
  localparam int WDOG   = 4096;
  localparam int S0M = 40, S0D = 4, S1M = 25, S1D = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_done = 1'b0;
  logic sel_pin = 1'b0;
  logic eng_busy = 1'b0;
  logic syn_locked = 1'b0;
  logic eng_wr, eng_start, syn_reset, ready, err, active_set;
  logic [1:0] eng_type;
  logic [8:0] eng_data;

  always #2.5 clk = ~clk;

  clk_reconfig_seq i_clk_reconfig_seq (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .sel_pin(sel_pin),
    .eng_wr(eng_wr), .eng_type(eng_type), .eng_data(eng_data),
    .eng_start(eng_start), .eng_busy(eng_busy), .syn_reset(syn_reset),
    .syn_locked(syn_locked), .ready(ready), .err(err), .active_set(active_set)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int P_WCFG = 0, P_IDLE = 1, P_WR = 2, P_ST = 3, P_WB = 4, P_RH = 5, P_WL = 6;
  int m_phase = P_WCFG;
  int q1 = 0, q2 = 0, cand = 0, runlen = 0, m_valid = 0, m_acc = 0;
  int m_slot = 0, m_tgt = 0, m_app = 0, m_seen = 0, m_pend = 0, m_need = 1;
  int m_ready = 0, m_err = 0, m_hold = 0, m_wd = 0;
  bit started = 0;

  function automatic int exp_param(input int set, input int slot);
    if (set == 0) return (slot == 0) ? S0M : S0D;
    return (slot == 0) ? S1M : S1D;
  endfunction

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_phase = P_WCFG; q1 = 0; q2 = 0; cand = 0; runlen = 0; m_valid = 0; m_acc = 0;
      m_slot = 0; m_tgt = 0; m_app = 0; m_seen = 0; m_pend = 0; m_need = 1;
      m_ready = 0; m_err = 0; m_hold = 0; m_wd = 0;
    end else begin
      int  old_phase;
      bit  en, full, chg;
      old_phase = m_phase;
      en   = cfg_done || (m_phase != P_WCFG);
      full = en && (q2 == cand) && (runlen == STABLE - 1);
      chg  = full && (m_valid != 0) && (cand != m_acc);
      case (m_phase)
        P_WCFG: if (cfg_done && m_valid != 0) m_phase = P_IDLE;
        P_IDLE: if (m_need != 0 || m_pend != 0 || m_acc != m_app) begin
          m_tgt = m_acc; m_pend = 0; m_need = 0; m_ready = 0; m_slot = 0;
          if (m_acc != m_app) m_phase = P_WR;
          else begin m_phase = P_RH; m_hold = 0; end
        end
        P_WR: if (m_slot == 0) m_slot = 1; else m_phase = P_ST;
        P_ST: begin m_phase = P_WB; m_seen = 0; m_wd = 0; end
        P_WB: begin
          if (m_seen != 0 && !eng_busy) begin m_app = m_tgt; m_phase = P_RH; m_hold = 0; end
          else if (m_wd == WDOG - 1) begin m_err = 1; m_phase = P_IDLE; end
          else m_wd++;
          if (eng_busy) m_seen = 1;
        end
        P_RH: if (m_hold == RSTC - 1) m_phase = P_WL; else m_hold++;
        P_WL: if (syn_locked) begin m_phase = P_IDLE; m_ready = 1; m_err = 0; end
        default: m_phase = P_WCFG;
      endcase
      if (chg && old_phase != P_IDLE) m_pend = 1;
      if (!en) begin
        q1 = 0; q2 = 0; cand = 0; runlen = 0; m_valid = 0; m_acc = 0;
      end else begin
        if (q2 != cand) begin cand = q2; runlen = 0; end
        else if (!full) runlen++;
        else begin m_acc = cand; m_valid = 1; end
        q2 = q1;
        q1 = int'(sel_pin);
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      int ewr;
      ewr = (m_phase == P_WR) ? 1 : 0;
      chk("R4 eng_wr", int'(eng_wr), ewr);
      chk("R4 eng_type", int'(eng_type), (ewr != 0) ? ((m_slot != 0) ? 2 : 1) : 0);
      chk("R3 eng_data", int'(eng_data), (ewr != 0) ? exp_param(m_tgt, m_slot) : 0);
      chk("R5 eng_start", int'(eng_start), (m_phase == P_ST) ? 1 : 0);
      chk("R7 syn_reset", int'(syn_reset), (m_phase == P_RH) ? 1 : 0);
      chk("R8 ready", int'(ready), m_ready);
      chk("R9 err", int'(err), m_err);
      chk("R3 active_set", int'(active_set), m_app);
    end
  end

  // ---------------- activity monitors ----------------
  int cnt_wr = 0, cnt_start = 0, cnt_rpulse = 0, rw = 0, last_rw = 0;
  bit prev_rst = 0;
  always @(negedge clk) begin
    if (eng_wr) cnt_wr++;
    if (eng_start) cnt_start++;
    if (syn_reset && !prev_rst) cnt_rpulse++;
    if (syn_reset) rw++;
    else if (prev_rst) begin last_rw = rw; rw = 0; end
    prev_rst = syn_reset;
  end

  // ---------------- engine and synthesizer models ----------------
  bit eng_on = 1;
  int busy_len = 5;
  int dly = 0, busy_left = 0, lk = 0;
  always @(negedge clk) begin
    if (eng_start && eng_on) dly = 3;
    else if (dly > 0) begin
      dly--;
      if (dly == 0) begin eng_busy = 1'b1; busy_left = busy_len; end
    end else if (eng_busy) begin
      busy_left--;
      if (busy_left == 0) eng_busy = 1'b0;
    end
    if (syn_reset) begin syn_locked = 1'b0; lk = 0; end
    else if (!syn_locked) begin
      lk++;
      if (lk >= 4) syn_locked = 1'b1;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base_wr, base_st, base_rp;
    wait_cycles(3);
    // R11: reset state
    chk("R11 ready after reset", int'(ready), 0);
    chk("R11 syn_reset after reset", int'(syn_reset), 0);
    chk("R11 active_set after reset", int'(active_set), 0);
    rst = 1'b0;

    // R1: pin activity before configuration is ignored
    for (int i = 0; i < 50; i++) begin
      sel_pin = ~sel_pin;
      wait_cycles(2);
    end
    sel_pin = 1'b0;
    wait_cycles(30);
    chk("R1 no writes before cfg", cnt_wr, 0);
    chk("R1 no reset before cfg", cnt_rpulse, 0);
    chk("R1 no start before cfg", cnt_start, 0);

    // R7: first decision, no change needed, reset still pulsed
    cfg_done = 1'b1;
    wait_cycles(100);
    chk("R7 reset pulse without reconfig", cnt_rpulse, 1);
    chk("R7 reset width", last_rw, RSTC);
    chk("R3 no writes when set matches", cnt_wr, 0);
    chk("R8 ready after lock", int'(ready), 1);

    // R3 R4 R5: switch to set 1
    sel_pin = 1'b1;
    wait_cycles(120);
    chk("R4 two writes", cnt_wr, 2);
    chk("R5 one start", cnt_start, 1);
    chk("R3 set 1 applied", int'(active_set), 1);
    chk("R7 second reset pulse", cnt_rpulse, 2);
    chk("R8 ready again", int'(ready), 1);

    // R2: short glitch ignored
    sel_pin = 1'b0;
    wait_cycles(5);
    sel_pin = 1'b1;
    wait_cycles(60);
    chk("R2 glitch: no writes", cnt_wr, 2);
    chk("R2 glitch: no reset", cnt_rpulse, 2);

    // R10 and R6: there-and-back change during a long busy period
    busy_len = 120;
    base_st = cnt_start; base_rp = cnt_rpulse; base_wr = cnt_wr;
    sel_pin = 1'b0;
    for (int i = 0; i < 200 && !eng_start; i++) wait_cycles(1);
    sel_pin = 1'b1;
    wait_cycles(30);
    sel_pin = 1'b0;
    wait_cycles(20);
    chk("R6 no reset while busy", int'(syn_reset), 0);
    chk("R6 set kept while busy", int'(active_set), 1);
    wait_cycles(400);
    chk("R10 single reconfig", cnt_start - base_st, 1);
    chk("R10 extra reset from pending", cnt_rpulse - base_rp, 2);
    chk("R10 writes", cnt_wr - base_wr, 2);
    chk("R3 set 0 applied", int'(active_set), 0);
    chk("R8 ready after pending", int'(ready), 1);

    // R9: stalled engine
    busy_len = 5;
    eng_on = 0;
    sel_pin = 1'b1;
    wait_cycles(4200);
    chk("R9 err raised", int'(err), 1);
    chk("R9 set unchanged", int'(active_set), 0);
    eng_on = 1;
    wait_cycles(4300);
    chk("R9 err cleared", int'(err), 0);
    chk("R9 retry applied", int'(active_set), 1);
    chk("R9 ready after retry", int'(ready), 1);

    // R11: reset in the middle of a sequence
    sel_pin = 1'b0;
    for (int i = 0; i < 100 && !eng_wr; i++) wait_cycles(1);
    rst = 1'b1;
    wait_cycles(1);
    chk("R11 eng_wr cleared", int'(eng_wr), 0);
    chk("R11 ready cleared", int'(ready), 0);
    chk("R11 set cleared", int'(active_set), 0);
    rst = 1'b0;
    wait_cycles(200);
    chk("R11 restart ready", int'(ready), 1);
    chk("R11 restart set", int'(active_set), 0);

    finish_run();
  end

endmodule